// File: doc/BRIEF.md
# Decoder Byte-Stream Transfer Router

This block sits between a CD data decoder and the rest of a subsystem. The decoder offers one byte per cycle over a valid/accept handshake. A 3-bit destination field in a control register selects where each byte goes. Two destinations are CPU-facing: bytes are packed in pairs into a 16-bit host word, which one of two CPUs then collects with a read. The other three destinations are memories, and each of those receives a one-cycle byte write strobe at an auto-incrementing address.

For the CPU destinations the block applies back-pressure. Once a full word is waiting, accept stays low until the selected CPU reads the word. For the memory destinations, the programmed address register holds the byte address divided by eight. A hidden 3-bit low counter supplies the rest of the address. That same counter also records which half of the host word comes next. The block sets an end-of-transfer flag when the decoder marks the last accepted byte.

Top module: `cdc_xfer_router`

## Requirements
- R1: After reset, `ctrl_rdata` is 0x0000, `host_rdata` is 0x0000, `in_ready` is 1 and `mem_we` is 0.
- R2: A control write loads the destination from `ctrl_wdest`, which holds bits 10:8 of the control word, and clears both flags. `ctrl_rdata` reads back as {end-of-transfer at bit 15, data-ready at bit 14, zeros at 13:11, destination at 10:8, zeros at 7:0}.
- R3: With destination 2 (main CPU) or 3 (sub CPU), the first accepted byte of a pair goes to bits 15:8 of the host word and the second goes to bits 7:0. The second byte sets data-ready.
- R4: While data-ready is set and the destination is 2 or 3, `in_ready` is 0 and the offered byte is held by the decoder, not consumed.
- R5: A read by the selected CPU (`main_rd` for 2, `sub_rd` for 3) returns the host word on `host_rdata` one cycle later and clears data-ready. A read by the other CPU returns 0xFFFF and leaves the flags unchanged.
- R6: A DMA address write loads the register with the written value and clears the low counter, so the next byte address is value*8. This also restarts host-word packing at the upper half.
- R7: For destination 5 (program RAM), each accepted byte produces, one cycle later, `mem_we`=1 for one cycle, `mem_sel`=1, `mem_wdata` equal to the byte and `mem_addr` equal to the byte address with bit 0 inverted. The address then increments by one.
- R8: For destination 4 (PCM RAM, `mem_sel`=0), the address is taken modulo 2^13 before use and before incrementing.
- R9: For destination 7 (word RAM), if `word_1m`=1 the address wraps at 17 bits and `mem_sel`=3 (sub CPU bank). If `word_1m`=0 it wraps at 18 bits and `mem_sel`=2.
- R10: For destination 7 with `word_1m`=0 and `word_ret`=1, the byte is accepted and the address still increments, but no write strobe is produced.
- R11: For destination values 0, 1 and 6, bytes are accepted with `in_ready`=1, no write occurs and the address is unchanged.
- R12: An accepted byte with `in_last`=1 sets the end-of-transfer flag. It stays set until the next control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdest | input | 3 | Destination field (control bits 10:8) |
| dma_wr | input | 1 | DMA address register write strobe |
| dma_wdata | input | 16 | DMA address value (byte address / 8) |
| main_rd | input | 1 | Main CPU host word read strobe |
| sub_rd | input | 1 | Sub CPU host word read strobe |
| word_1m | input | 1 | Word RAM split (1M) mode |
| word_ret | input | 1 | Word RAM returned to main CPU (2M mode) |
| in_valid | input | 1 | Decoder byte valid |
| in_data | input | 8 | Decoder byte |
| in_last | input | 1 | Byte is last of transfer |
| in_ready | output | 1 | Byte accepted this cycle when valid |
| ctrl_rdata | output | 16 | Control register read value |
| host_rdata | output | 16 | Host word read result |
| mem_we | output | 1 | Memory byte write strobe |
| mem_sel | output | 2 | 0 PCM, 1 program, 2 word 2M, 3 word 1M |
| mem_addr | output | 19 | Byte address, bit 0 inverted |
| mem_wdata | output | 8 | Byte to write |

## Verification
The hardest state to reach is a byte that has been stalled for several cycles and is released by a CPU read in the same cycle that data-ready clears. The bench holds `in_valid` high through the stall and injects the selected read in the middle. It then confirms that the held byte lands in the upper half of a new pair, with no byte dropped or duplicated. The address wrap points are reached by programming the DMA register near the top of each window and streaming across the boundary. A DMA write in the middle of a pair, and a run of bytes to an invalid destination, are both followed by traffic that exposes the resulting address or packing phase at the ports.

// File: rtl/cdc_xfer_pkg.sv
package cdc_xfer_pkg;
  localparam logic [2:0] DST_MAIN = 3'd2;
  localparam logic [2:0] DST_SUB  = 3'd3;
  localparam logic [2:0] DST_PCM  = 3'd4;
  localparam logic [2:0] DST_PROG = 3'd5;
  localparam logic [2:0] DST_WORD = 3'd7;

  typedef enum logic [1:0] {
    SEL_PCM    = 2'd0,
    SEL_PROG   = 2'd1,
    SEL_WORD2M = 2'd2,
    SEL_WORD1M = 2'd3
  } mem_sel_e;
endpackage

// File: rtl/cdc_addr_gen.sv
module cdc_addr_gen #(
  parameter int REG_W = 16,
  parameter int LOW_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [REG_W-1:0]         load_val,
  input  logic                     step,
  input  logic [REG_W+LOW_W-1:0]   wrap_mask,
  input  logic                     phase_set,
  input  logic                     phase_clr,
  output logic [REG_W+LOW_W-1:0]   cur_addr,
  output logic                     low_nz
);
  localparam int ADDR_W = REG_W + LOW_W;

  logic [REG_W-1:0]  reg_q;
  logic [LOW_W-1:0]  low_q;
  logic [ADDR_W-1:0] nxt;

  assign cur_addr = {reg_q, low_q};
  assign low_nz   = |low_q;
  assign nxt      = (cur_addr & wrap_mask) + {{(ADDR_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q <= '0;
      low_q <= '0;
    end else if (load) begin
      reg_q <= load_val;
      low_q <= '0;
    end else if (step) begin
      {reg_q, low_q} <= nxt;
    end else if (phase_set) begin
      low_q <= LOW_W'(1);
    end else if (phase_clr) begin
      low_q <= '0;
    end
  end

  // R6: a register load restarts the low counter
  a_r6_load_clears_low: assert property (@(posedge clk) disable iff (rst)
    load |=> (low_q == '0 && reg_q == $past(load_val)));
endmodule

// File: rtl/cdc_host_pack.sv
module cdc_host_pack #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  take,
  input  logic                  hi_phase,
  input  logic [BYTE_W-1:0]     byte_in,
  input  logic                  rd_hit,
  input  logic                  flag_clr,
  output logic [2*BYTE_W-1:0]   host_word,
  output logic                  dsr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      host_word <= '0;
    end else if (take) begin
      if (hi_phase) host_word[2*BYTE_W-1:BYTE_W] <= byte_in;
      else          host_word[BYTE_W-1:0]        <= byte_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     dsr <= 1'b0;
    else if (flag_clr)           dsr <= 1'b0;
    else if (take && !hi_phase)  dsr <= 1'b1;
    else if (rd_hit)             dsr <= 1'b0;
  end

  // R3: data-ready only rises from a lower-half byte
  a_r3_dsr_from_low_byte: assert property (@(posedge clk) disable iff (rst)
    $rose(dsr) |-> $past(take && !hi_phase));
  // R3: upper half captures the first byte of a pair
  a_r3_upper_capture: assert property (@(posedge clk) disable iff (rst)
    (take && hi_phase) |=> host_word[2*BYTE_W-1:BYTE_W] == $past(byte_in));
endmodule

// File: rtl/cdc_xfer_router.sv
module cdc_xfer_router
  import cdc_xfer_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int LOW_W  = 3,
  parameter int BYTE_W = 8,
  parameter int PCM_W  = 13,
  parameter int W1M_W  = 17,
  parameter int W2M_W  = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ctrl_wr,
  input  logic [2:0]               ctrl_wdest,
  input  logic                     dma_wr,
  input  logic [REG_W-1:0]         dma_wdata,
  input  logic                     main_rd,
  input  logic                     sub_rd,
  input  logic                     word_1m,
  input  logic                     word_ret,
  input  logic                     in_valid,
  input  logic [BYTE_W-1:0]        in_data,
  input  logic                     in_last,
  output logic                     in_ready,
  output logic [15:0]              ctrl_rdata,
  output logic [2*BYTE_W-1:0]      host_rdata,
  output logic                     mem_we,
  output logic [1:0]               mem_sel,
  output logic [REG_W+LOW_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0]        mem_wdata
);
  localparam int ADDR_W = REG_W + LOW_W;
  localparam logic [ADDR_W-1:0] MASK_PCM = {{(ADDR_W-PCM_W){1'b0}}, {PCM_W{1'b1}}};
  localparam logic [ADDR_W-1:0] MASK_1M  = {{(ADDR_W-W1M_W){1'b0}}, {W1M_W{1'b1}}};
  localparam logic [ADDR_W-1:0] MASK_2M  = {{(ADDR_W-W2M_W){1'b0}}, {W2M_W{1'b1}}};
  localparam logic [ADDR_W-1:0] MASK_ALL = {ADDR_W{1'b1}};

  logic [2:0]          dest_q;
  logic                eot_q;
  logic                dsr;
  logic [2*BYTE_W-1:0] host_word;
  logic [ADDR_W-1:0]   cur_addr;
  logic                low_nz;

  logic is_cpu, is_mem, acc, take, step, hi_phase, rd_hit, any_rd;
  logic [ADDR_W-1:0] wrap_mask;
  mem_sel_e          sel_n;
  logic              we_n;

  assign is_cpu   = (dest_q == DST_MAIN) || (dest_q == DST_SUB);
  assign is_mem   = (dest_q == DST_PCM) || (dest_q == DST_PROG) || (dest_q == DST_WORD);
  assign in_ready = !(is_cpu && dsr);
  assign acc      = in_valid && in_ready;
  assign take     = acc && is_cpu;
  assign step     = acc && is_mem;
  assign hi_phase = !low_nz;
  assign rd_hit   = (main_rd && dest_q == DST_MAIN) || (sub_rd && dest_q == DST_SUB);
  assign any_rd   = main_rd || sub_rd;

  always_comb begin
    wrap_mask = MASK_ALL;
    sel_n     = SEL_PROG;
    we_n      = step;
    unique case (dest_q)
      DST_PCM: begin
        wrap_mask = MASK_PCM;
        sel_n     = SEL_PCM;
      end
      DST_WORD: begin
        if (word_1m) begin
          wrap_mask = MASK_1M;
          sel_n     = SEL_WORD1M;
        end else begin
          wrap_mask = MASK_2M;
          sel_n     = SEL_WORD2M;
          we_n      = step && !word_ret;
        end
      end
      default: ;
    endcase
  end

  cdc_addr_gen #(.REG_W(REG_W), .LOW_W(LOW_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load      (dma_wr),
    .load_val  (dma_wdata),
    .step      (step),
    .wrap_mask (wrap_mask),
    .phase_set (take && hi_phase),
    .phase_clr (take && !hi_phase),
    .cur_addr  (cur_addr),
    .low_nz    (low_nz)
  );

  cdc_host_pack #(.BYTE_W(BYTE_W)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .hi_phase  (hi_phase),
    .byte_in   (in_data),
    .rd_hit    (rd_hit),
    .flag_clr  (ctrl_wr),
    .host_word (host_word),
    .dsr       (dsr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dest_q <= 3'd0;
      eot_q  <= 1'b0;
    end else begin
      if (ctrl_wr) dest_q <= ctrl_wdest;
      if (ctrl_wr)                    eot_q <= 1'b0;
      else if (acc && in_last)        eot_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (rd_hit)  host_rdata <= host_word;
    else if (any_rd)  host_rdata <= {(2*BYTE_W){1'b1}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_sel   <= 2'd0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= we_n;
      if (we_n) begin
        mem_sel   <= sel_n;
        mem_addr  <= (cur_addr & wrap_mask) ^ {{(ADDR_W-1){1'b0}}, 1'b1};
        mem_wdata <= in_data;
      end
    end
  end

  assign ctrl_rdata = {eot_q, dsr, 3'b000, dest_q, 8'h00};

  // R4: a full host word blocks the decoder
  a_r4_stall_when_full: assert property (@(posedge clk) disable iff (rst)
    (is_cpu && dsr) |-> !in_ready);
  // R7: every strobe follows an accepted byte
  a_r7_strobe_after_accept: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(in_valid && in_ready));
  // R8: PCM writes stay inside the 13-bit window
  a_r8_pcm_window: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_sel == SEL_PCM) |-> mem_addr[ADDR_W-1:PCM_W] == '0);
  // R10: returned 2M word RAM never gets a strobe
  a_r10_ret_blocks: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_sel == SEL_WORD2M) |-> !$past(word_ret));
  // R12: end-of-transfer rises only on an accepted last byte
  a_r12_eot_source: assert property (@(posedge clk) disable iff (rst)
    $rose(eot_q) |-> $past(in_valid && in_ready && in_last));
  // R5: a read by the unselected CPU yields all ones
  a_r5_foreign_read: assert property (@(posedge clk) disable iff (rst)
    (main_rd && !sub_rd && dest_q != DST_MAIN) |=> host_rdata == {(2*BYTE_W){1'b1}});
endmodule

// File: tb/tb_cdc_xfer_router.sv
module tb_cdc_xfer_router;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_wr = 0, dma_wr = 0, main_rd = 0, sub_rd = 0;
  logic [2:0] ctrl_wdest = 0;
  logic [15:0] dma_wdata = 0;
  logic word_1m = 0, word_ret = 0;
  logic in_valid = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic in_ready, mem_we;
  logic [15:0] ctrl_rdata, host_rdata;
  logic [1:0] mem_sel;
  logic [18:0] mem_addr;
  logic [7:0] mem_wdata;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  cdc_xfer_router dut (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdest(ctrl_wdest),
    .dma_wr(dma_wr), .dma_wdata(dma_wdata), .main_rd(main_rd), .sub_rd(sub_rd),
    .word_1m(word_1m), .word_ret(word_ret), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .ctrl_rdata(ctrl_rdata),
    .host_rdata(host_rdata), .mem_we(mem_we), .mem_sel(mem_sel),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [2:0]  m_dest;
  logic [18:0] m_addr, m_a;
  logic [15:0] m_host, m_rdata;
  bit m_dsr, m_eot, m_we, m_rdy;
  logic [1:0]  m_sel;
  logic [18:0] m_maddr;
  logic [7:0]  m_wd;

  always @(posedge clk) begin
    if (rst) begin
      m_dest = 0; m_addr = 0; m_host = 0; m_rdata = 0;
      m_dsr = 0; m_eot = 0; m_we = 0; m_sel = 0; m_maddr = 0; m_wd = 0;
    end else begin
      m_rdy = !((m_dest == 2 || m_dest == 3) && m_dsr);
      m_we = 0;
      if ((main_rd && m_dest == 2) || (sub_rd && m_dest == 3)) begin
        m_rdata = m_host; m_dsr = 0;
      end else if (main_rd || sub_rd) m_rdata = 16'hFFFF;
      if (in_valid && m_rdy) begin
        if (in_last) m_eot = 1;
        case (m_dest)
          3'd2, 3'd3: begin
            if (m_addr[2:0] == 0) begin m_host[15:8] = in_data; m_addr[2:0] = 3'd1; end
            else begin m_host[7:0] = in_data; m_addr[2:0] = 3'd0; m_dsr = 1; end
          end
          3'd4: begin
            m_a = m_addr % 19'h2000;
            m_we = 1; m_sel = 0; m_maddr = m_a ^ 19'd1; m_wd = in_data; m_addr = m_a + 1;
          end
          3'd5: begin
            m_we = 1; m_sel = 1; m_maddr = m_addr ^ 19'd1; m_wd = in_data; m_addr = m_addr + 1;
          end
          3'd7: begin
            if (word_1m) begin
              m_a = m_addr % 19'h20000; m_we = 1; m_sel = 3;
            end else begin
              m_a = m_addr % 19'h40000; m_we = !word_ret; m_sel = 2;
            end
            if (m_we) begin m_maddr = m_a ^ 19'd1; m_wd = in_data; end
            m_addr = m_a + 1;
          end
          default: ;
        endcase
      end
      if (dma_wr) m_addr = {dma_wdata, 3'b000};
      if (ctrl_wr) begin m_dest = ctrl_wdest; m_eot = 0; m_dsr = 0; end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R4", "in_ready", in_ready, m_rdy_now());
      chk("R2", "ctrl_rdata", ctrl_rdata, {m_eot, m_dsr, 3'b000, m_dest, 8'h00});
      chk("R5", "host_rdata", host_rdata, m_rdata);
      chk("R7", "mem_we", mem_we, m_we);
      if (m_we) begin
        chk("R7", "mem_addr", mem_addr, m_maddr);
        chk("R7", "mem_sel", mem_sel, m_sel);
        chk("R7", "mem_wdata", mem_wdata, m_wd);
      end
    end
  end

  function automatic bit m_rdy_now();
    return !((m_dest == 2 || m_dest == 3) && m_dsr);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic wr_ctrl(input logic [2:0] d);
    @(negedge clk); ctrl_wr = 1; ctrl_wdest = d;
    @(negedge clk); ctrl_wr = 0;
  endtask

  task automatic wr_dma(input logic [15:0] v);
    @(negedge clk); dma_wr = 1; dma_wdata = v;
    @(negedge clk); dma_wr = 0;
  endtask

  task automatic rd(input bit main);
    @(negedge clk); if (main) main_rd = 1; else sub_rd = 1;
    @(negedge clk); main_rd = 0; sub_rd = 0;
  endtask

  task automatic send(input logic [7:0] d, input bit last);
    int n = 0;
    @(negedge clk); in_valid = 1; in_data = d; in_last = last;
    while (!in_ready && n < 100) begin @(negedge clk); n++; end
    @(negedge clk); in_valid = 0; in_last = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "reset ctrl", ctrl_rdata, 16'h0000);
    chk("R1", "reset host", host_rdata, 16'h0000);
    chk("R1", "reset ready", in_ready, 1'b1);
    chk("R1", "reset we", mem_we, 1'b0);

    // Sub CPU pack, stall and release
    wr_ctrl(3'd3);
    chk("R2", "dest readback", ctrl_rdata, 16'h0300);
    send(8'hAB, 0); send(8'hCD, 0);
    chk("R3", "dsr after pair", ctrl_rdata, 16'h4300);
    rd(1);
    chk("R5", "foreign read", host_rdata, 16'hFFFF);
    chk("R5", "foreign read keeps dsr", ctrl_rdata, 16'h4300);
    @(negedge clk); in_valid = 1; in_data = 8'hEF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R4", "stalled ready", in_ready, 1'b0);
    end
    sub_rd = 1;
    @(negedge clk); sub_rd = 0;
    chk("R5", "selected read", host_rdata, 16'hABCD);
    chk("R5", "dsr cleared", in_ready, 1'b1);
    @(negedge clk); in_valid = 0;
    send(8'h12, 1);
    chk("R12", "eot set", ctrl_rdata, 16'hC300);
    rd(0);
    chk("R3", "held byte upper", host_rdata, 16'hEF12);

    // Main CPU, DMA write mid-pair restarts packing
    wr_ctrl(3'd2);
    chk("R2", "flags cleared", ctrl_rdata, 16'h0200);
    send(8'h77, 0);
    wr_dma(16'h0000);
    send(8'h55, 0); send(8'h66, 0);
    rd(1);
    chk("R6", "phase restart", host_rdata, 16'h5566);

    // PCM wrap at 13 bits
    wr_ctrl(3'd4); wr_dma(16'h03FF);
    for (int i = 0; i < 8; i++) send(8'(i), 0);
    send(8'h99, 0);
    chk("R8", "pcm wrap addr", mem_addr, 19'h00001);
    chk("R8", "pcm sel", mem_sel, 2'd0);

    // Program RAM
    wr_ctrl(3'd5); wr_dma(16'h0010);
    send(8'h3C, 0);
    chk("R7", "prog addr", mem_addr, 19'h00081);
    chk("R7", "prog data", mem_wdata, 8'h3C);
    send(8'h3D, 0);
    chk("R7", "prog addr2", mem_addr, 19'h00080);

    // Word RAM 1M wrap at 17 bits
    word_1m = 1;
    wr_ctrl(3'd7); wr_dma(16'hFFFF);
    for (int i = 0; i < 8; i++) send(8'(i + 16), 0);
    send(8'hA5, 0);
    chk("R9", "1M wrap addr", mem_addr, 19'h00001);
    chk("R9", "1M sel", mem_sel, 2'd3);

    // Word RAM 2M with RET
    word_1m = 0; word_ret = 1;
    wr_dma(16'h0020);
    send(8'h01, 0);
    chk("R10", "ret no strobe", mem_we, 1'b0);
    send(8'h02, 0);
    chk("R10", "ret no strobe 2", mem_we, 1'b0);
    word_ret = 0;
    send(8'h03, 0);
    chk("R10", "addr advanced", mem_addr, 19'h00103);
    chk("R9", "2M sel", mem_sel, 2'd2);

    // Invalid destination
    wr_ctrl(3'd1);
    for (int i = 0; i < 3; i++) begin
      send(8'h44, 0);
      chk("R11", "invalid no write", mem_we, 1'b0);
    end
    wr_ctrl(3'd7);
    send(8'h45, 0);
    chk("R11", "addr unchanged", mem_addr, 19'h00102);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule